// File: doc/BRIEF.md
# Interlaced Composite Video Level Sequencer

This block produces a two-field interlaced video waveform that never stops. The waveform is a stream of 3-bit drive levels, and the level can change only on a 1 µs tick enable. Each field opens with a vertical interval of half-line pulses: six narrow equalizing pulses, then five broad sync pulses, then five more narrow equalizing pulses. Active lines follow. The first field has 304 of them and the second has 305. Adding the eight-line vertical interval of each field gives 312 and 313 lines, 625 in all. After the last line of the second field the pattern restarts at once.

Every active line has 64 ticks: a horizontal sync, a back porch, 52 picture ticks and a front porch. For picture ticks the block drives a linear sample address to an external pixel store one tick ahead of use. It takes back an 8-bit luminance byte and scales it to one of seven levels above sync. This keeps picture content clear of the sync level. A field flag and a line-start strobe let the surrounding logic follow the raster.

Top module: `interlace_level_seq`

## Requirements
- R1: While reset is asserted and after its release, before the first tick, `level_o` is 0 and `field_o` is 0. The first tick interval is the first tick of the first pre-equalizing pulse of field 0.
- R2: Each field starts with 6 pre-equalizing pulses. Each pulse is 2 ticks at level 0 followed by 30 ticks at level 1.
- R3: Next come 5 broad pulses. Each is 30 ticks at level 0 followed by 2 ticks at level 1.
- R4: Next come 5 post-equalizing pulses, each 2 ticks at level 0 and 30 ticks at level 1.
- R5: Each active line is 4 ticks at level 0, then 6 ticks at level 1, then 52 picture ticks, then 2 ticks at level 1.
- R6: Field 0 carries 304 active lines and field 1 carries 305. `field_o` is 0 during every tick of field 0 and 1 during every tick of field 1.
- R7: A picture tick drives level floor(Y*6/255)+1, where Y is the byte on `pix_data_i`. The level is always between 1 and 7.
- R8: During the tick interval just before a picture tick, `pix_req_o` is 1 and `pix_addr_o` equals sample + line*52 + field*312*52. Here sample runs 0..51 and line counts active lines from 0 within the field. In every other tick interval `pix_req_o` is 0. `pix_data_i` is sampled on the tick edge that starts the picture tick.
- R9: The tick after the last front-porch tick of field 1 is the first pre-equalizing tick of field 0, with no gap.
- R10: While `tick_i` is 0, `level_o` and `field_o` do not change.
- R11: `line_start_o` is high for exactly one clock, the clock after the tick edge that enters the first sync tick of an active line. It is 0 at every other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-clock enable, one per 1 µs tick |
| pix_data_i | input | 8 | Luminance byte for the requested address |
| level_o | output | 3 | Drive level: 0 sync, 1 blank, 1..7 picture |
| pix_req_o | output | 1 | Next tick is a picture tick |
| pix_addr_o | output | 15 | Linear sample address of the next picture tick |
| field_o | output | 1 | Field currently being output |
| line_start_o | output | 1 | One-clock strobe at the start of an active line |

## Verification
The assertions check several things on every clock. Level and field hold while no tick arrives. A picture tick never reaches the sync level. Addresses stay inside the two-field range. The line-start strobe lasts one clock and falls only on sync level. A field change always lands on a sync tick. Pulse counts, segment lengths, the 304/305 line split, the exact address values, the luminance scaling thresholds and the seamless wrap into the next frame can only be shown by the bench. It plays two whole frames against an independently built tick-by-tick expectation, with tick gaps inserted.

// File: rtl/interlace_level_seq.sv
module interlace_level_seq #(
  parameter int PRE_PULSES   = 6,
  parameter int BROAD_PULSES = 5,
  parameter int POST_PULSES  = 5,
  parameter int HALF_TICKS   = 32,
  parameter int EQ_LOW       = 2,
  parameter int BROAD_LOW    = 30,
  parameter int HSYNC        = 4,
  parameter int BPORCH       = 6,
  parameter int PIX          = 52,
  parameter int FPORCH       = 2,
  parameter int LINES_F0     = 304,
  parameter int LINES_F1     = 305,
  parameter int FIELD_STRIDE = 312,
  parameter int LUMA_W       = 8,
  parameter int LVL_W        = 3,
  parameter int LVL_STEPS    = 6,
  parameter int ADDR_W       = $clog2(2 * FIELD_STRIDE * PIX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [LUMA_W-1:0] pix_data_i,
  output logic [LVL_W-1:0]  level_o,
  output logic              pix_req_o,
  output logic [ADDR_W-1:0] pix_addr_o,
  output logic              field_o,
  output logic              line_start_o
);

  localparam int LINE_TICKS = HSYNC + BPORCH + PIX + FPORCH;
  localparam int PIX_FIRST  = HSYNC + BPORCH;
  localparam int PIX_LAST   = PIX_FIRST + PIX - 1;
  localparam int POS_W      = $clog2(LINE_TICKS);
  localparam int CNT_W      = $clog2(LINES_F1 + 1);
  localparam int LUMA_MAX   = (1 << LUMA_W) - 1;
  localparam logic [LVL_W-1:0] LVL_SYNC  = '0;
  localparam logic [LVL_W-1:0] LVL_BLANK = LVL_W'(1);

  typedef enum logic [1:0] {SEG_PRE, SEG_BROAD, SEG_POST, SEG_LINE} seg_t;

  function automatic logic [LVL_W-1:0] scale_luma(input logic [LUMA_W-1:0] y);
    int acc;
    acc = 1;
    for (int k = 1; k <= LVL_STEPS; k++)
      if (int'(y) * LVL_STEPS >= LUMA_MAX * k) acc++;
    return LVL_W'(acc);
  endfunction

  logic             field_q, n_field;
  seg_t             seg_q, n_seg;
  logic [CNT_W-1:0] cnt_q, n_cnt, seg_last;
  logic [POS_W-1:0] pos_q, n_pos;
  logic [LVL_W-1:0] level_q, n_level;
  logic             ls_q, n_pix;

  always_comb begin
    case (seg_q)
      SEG_PRE:   seg_last = CNT_W'(PRE_PULSES - 1);
      SEG_BROAD: seg_last = CNT_W'(BROAD_PULSES - 1);
      SEG_POST:  seg_last = CNT_W'(POST_PULSES - 1);
      default:   seg_last = field_q ? CNT_W'(LINES_F1 - 1) : CNT_W'(LINES_F0 - 1);
    endcase
  end

  always_comb begin
    n_field = field_q;
    n_seg   = seg_q;
    n_cnt   = cnt_q;
    n_pos   = pos_q + POS_W'(1);
    if ((seg_q != SEG_LINE && pos_q == POS_W'(HALF_TICKS - 1)) ||
        (seg_q == SEG_LINE && pos_q == POS_W'(LINE_TICKS - 1))) begin
      n_pos = '0;
      n_cnt = cnt_q + CNT_W'(1);
      if (cnt_q == seg_last) begin
        n_cnt = '0;
        case (seg_q)
          SEG_PRE:   n_seg = SEG_BROAD;
          SEG_BROAD: n_seg = SEG_POST;
          SEG_POST:  n_seg = SEG_LINE;
          default: begin
            n_seg   = SEG_PRE;
            n_field = ~field_q;
          end
        endcase
      end
    end
  end

  assign n_pix = (n_seg == SEG_LINE) && (n_pos >= POS_W'(PIX_FIRST)) &&
                 (n_pos <= POS_W'(PIX_LAST));

  always_comb begin
    case (n_seg)
      SEG_BROAD: n_level = (n_pos < POS_W'(BROAD_LOW)) ? LVL_SYNC : LVL_BLANK;
      SEG_LINE:  n_level = (n_pos < POS_W'(HSYNC)) ? LVL_SYNC :
                           n_pix ? scale_luma(pix_data_i) : LVL_BLANK;
      default:   n_level = (n_pos < POS_W'(EQ_LOW)) ? LVL_SYNC : LVL_BLANK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= 1'b0;
      seg_q   <= SEG_PRE;
      cnt_q   <= '0;
      pos_q   <= '0;
      level_q <= LVL_SYNC;
      ls_q    <= 1'b0;
    end else begin
      ls_q <= tick_i && (n_seg == SEG_LINE) && (n_pos == '0);
      if (tick_i) begin
        field_q <= n_field;
        seg_q   <= n_seg;
        cnt_q   <= n_cnt;
        pos_q   <= n_pos;
        level_q <= n_level;
      end
    end
  end

  assign pix_req_o    = n_pix;
  assign pix_addr_o   = n_pix ? ADDR_W'(n_pos - POS_W'(PIX_FIRST)) +
                                ADDR_W'(n_cnt) * ADDR_W'(PIX) +
                                (n_field ? ADDR_W'(FIELD_STRIDE * PIX) : '0)
                              : '0;
  assign level_o      = level_q;
  assign field_o      = field_q;
  assign line_start_o = ls_q;

endmodule

// File: rtl/interlace_level_seq_chk.sv
module interlace_level_seq_chk #(
  parameter int ADDR_W = 15,
  parameter int LIMIT  = 32448
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic [2:0]        level_o,
  input logic              pix_req_o,
  input logic [ADDR_W-1:0] pix_addr_o,
  input logic              field_o,
  input logic              line_start_o
);

  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(level_o)); // R10

  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(field_o)); // R10

  AST_PIX_ABOVE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && pix_req_o) |=> (level_o != 3'd0)); // R7

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_req_o |-> (int'(pix_addr_o) < LIMIT)); // R8

  AST_LS_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    line_start_o |=> !line_start_o); // R11

  AST_LS_AT_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    line_start_o |-> (level_o == 3'd0)); // R5

  AST_FIELD1_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(field_o) |-> (level_o == 3'd0)); // R6

  AST_WRAP_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(field_o) |-> (level_o == 3'd0)); // R9

endmodule

bind interlace_level_seq interlace_level_seq_chk #(.ADDR_W(ADDR_W), .LIMIT(2 * FIELD_STRIDE * PIX)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .level_o(level_o),
  .pix_req_o(pix_req_o), .pix_addr_o(pix_addr_o), .field_o(field_o),
  .line_start_o(line_start_o)
);

// File: tb/interlace_level_seq_bench.sv
module interlace_level_seq_bench;

  typedef struct {
    int lvl;
    bit pix;
    int addr;
    bit fld;
    bit ls;
    int req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic [7:0]  pix_data_i;
  logic [2:0]  level_o;
  logic        pix_req_o;
  logic [14:0] pix_addr_o;
  logic        field_o;
  logic        line_start_o;

  item_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign pix_data_i = pix_addr_o[7:0];

  interlace_level_seq u_interlace_level_seq (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .pix_data_i(pix_data_i),
    .level_o(level_o), .pix_req_o(pix_req_o), .pix_addr_o(pix_addr_o),
    .field_o(field_o), .line_start_o(line_start_o)
  );

  function automatic string rname(input int r);
    case (r)
      1: return "R1";   2: return "R2";   3: return "R3";
      4: return "R4";   5: return "R5";   6: return "R6";
      7: return "R7";   8: return "R8";   9: return "R9";
      10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic chk(input bit ok, input int r, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rname(r), what, act, exp);
    end
  endtask

  task automatic push(input int lvl, input bit pix, input int addr, input bit fld,
                      input bit ls, input int r);
    item_t it;
    it.lvl = lvl; it.pix = pix; it.addr = addr; it.fld = fld; it.ls = ls; it.req = r;
    exp_q.push_back(it);
  endtask

  task automatic drive_field(input bit f);
    for (int p = 0; p < 6; p++) begin
      for (int t = 0; t < 32; t++) push(t < 2 ? 0 : 1, 0, 0, f, 0, 2);
    end
    for (int p = 0; p < 5; p++) begin
      for (int t = 0; t < 32; t++) push(t < 30 ? 0 : 1, 0, 0, f, 0, 3);
    end
    for (int p = 0; p < 5; p++) begin
      for (int t = 0; t < 32; t++) push(t < 2 ? 0 : 1, 0, 0, f, 0, 4);
    end
    for (int ln = 0; ln < (f ? 305 : 304); ln++) begin
      for (int t = 0; t < 4; t++) push(0, 0, 0, f, t == 0, 5);
      for (int t = 0; t < 6; t++) push(1, 0, 0, f, 0, 5);
      for (int s = 0; s < 52; s++) begin
        int a;
        a = s + ln * 52 + f * 312 * 52;
        push(((a % 256) * 6) / 255 + 1, 1, a, f, 0, 7);
      end
      for (int t = 0; t < 2; t++) push(1, 0, 0, f, 0, 5);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cyc;
    bit t;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(level_o == 3'd0, 1, level_o, 0, "level in reset");
    chk(field_o == 1'b0, 1, field_o, 0, "field in reset");
    rst_n = 1'b1;
    for (int fr = 0; fr < 2; fr++) begin
      int base;
      base = exp_q.size();
      drive_field(0);
      drive_field(1);
      if (fr == 1) exp_q[base].req = 9;
    end
    @(negedge clk);
    chk(level_o == 3'd0, 1, level_o, 0, "level after reset");
    chk(field_o == 1'b0, 1, field_o, 0, "field after reset");
    chk(line_start_o == 1'b0, 11, line_start_o, 0, "strobe after reset");
    cyc = 0;
    while (exp_q.size() > 1 && !done) begin
      t = (cyc % 61) < 58;
      if (t) begin
        chk(pix_req_o == exp_q[1].pix, 8, pix_req_o, exp_q[1].pix, "request");
        if (exp_q[1].pix)
          chk(int'(pix_addr_o) == exp_q[1].addr, 8, pix_addr_o, exp_q[1].addr, "address");
      end
      tick_i = t;
      @(negedge clk);
      tick_i = 1'b0;
      if (t) begin
        void'(exp_q.pop_front());
        chk(int'(level_o) == exp_q[0].lvl, exp_q[0].req, level_o, exp_q[0].lvl, "level");
        chk(field_o == exp_q[0].fld, 6, field_o, exp_q[0].fld, "field");
        chk(line_start_o == exp_q[0].ls, 11, line_start_o, exp_q[0].ls, "line start");
      end else begin
        chk(int'(level_o) == exp_q[0].lvl, 10, level_o, exp_q[0].lvl, "level held");
        chk(field_o == exp_q[0].fld, 10, field_o, exp_q[0].fld, "field held");
        chk(line_start_o == 1'b0, 11, line_start_o, 0, "strobe without tick");
      end
      cyc++;
    end
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule